// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter

This block sits behind a bit-level ARINC 429 receiver. When the receiver has collected a full 32-bit word it raises a one-cycle end-of-word strobe alongside the word. The filter replaces the top bit of the word with a parity-error flag. It then applies two optional acceptance tests:

- a check of the two routing bits (ARINC bits 9 and 10) against programmed values;
- a lookup of the 8-bit label in a programmable table of sixteen labels.

A word that passes every enabled test goes into a 32-entry receive queue. A rejected word is discarded with no trace.

A host drains the queue through a 16-bit data port. A select line chooses the low or the high half of the word at the head. The head advances only when the high half is taken with a read strobe. The queue reports data-ready, half-full and full status. A sticky overflow flag records that an accepted word was lost because the queue was full.

ARINC bit n is carried on `word_in[n-1]`. The label is therefore `word_in[7:0]`, the routing bits are `word_in[9:8]`, and the parity bit is `word_in[31]`.

Top module: `a429f_word_filter`

## Requirements
- R1: Bit 31 of each stored word is 0 when the 32 incoming bits hold an odd number of ones, and 1 when they hold an even number. Bits 30:0 are stored unchanged, and a word with the flag set is still stored.
- R2: A word is evaluated and possibly stored only in a cycle where `eos` is high. With `eos` low, `word_in` has no effect on the queue.
- R3: With `route_en` high, a word is stored only if `word_in[8]==route_val[0]` and `word_in[9]==route_val[1]`. With `route_en` low, these bits do not affect acceptance.
- R4: With `label_en` high, a word is stored only if `word_in[7:0]` equals one of the sixteen table entries, compared bit for bit with no reversal. With `label_en` low, the label does not affect acceptance.
- R5: A pulse on `lbl_wr` writes `lbl_val` into table entry `lbl_idx`. Reset clears every entry to 0x00.
- R6: Stored words are returned in arrival order, and up to 32 words are held at once.
- R7: `rd_data` shows bits 15:0 of the head word when `rd_sel` is 0 and bits 31:16 when `rd_sel` is 1. A `rd_strobe` with `rd_sel`=1 removes the head word; a strobe with `rd_sel`=0 removes nothing.
- R8: A removing read while the queue is empty changes nothing, and the next stored word is read back correctly.
- R9: `data_ready` is high when at least 1 word is held, `half_full` when at least 16 are held, and `full` when 32 are held.
- R10: An accepted word that arrives while the queue is full is dropped and the held words are kept. `overflow` then rises and stays high until reset.
- R11: After reset, `data_ready`, `half_full`, `full` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 32 | Received word, ARINC bit n on index n-1 |
| eos | input | 1 | End-of-word strobe, one cycle per word |
| route_en | input | 1 | Enables the bits 9/10 test |
| route_val | input | 2 | Expected values of bits 10 and 9 |
| label_en | input | 1 | Enables the label table test |
| lbl_wr | input | 1 | Label table write strobe |
| lbl_idx | input | 4 | Label table entry index |
| lbl_val | input | 8 | Label value to write |
| rd_sel | input | 1 | Half select: 0 low half, 1 high half |
| rd_strobe | input | 1 | Read strobe; pops the head word when rd_sel is 1 |
| rd_data | output | 16 | Selected half of the head word |
| data_ready | output | 1 | Queue not empty |
| half_full | output | 1 | At least half the queue is used |
| full | output | 1 | Queue full |
| overflow | output | 1 | Sticky: an accepted word was lost |

## Verification
The bench builds the block with its default parameters: a 32-word queue and a 16-entry label table. With these values the half-full threshold at 16 and the full point at 32 are reached within a few dozen writes, so the directed fill, the drop at full and the sticky overflow are all exercised at their exact boundaries. The random phase draws half of its labels from the programmed table and reprograms the routing and label enables as it runs. This covers every combination of the two filters across many arrival and read orderings.

// File: rtl/a429f_pkg.sv
package a429f_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int LABEL_W = 8;
    localparam int ROUTE_W = 2;
    localparam int BODY_W  = WORD_W - 1 - ROUTE_W - LABEL_W;

    // Stored word layout, MSB first
    typedef struct packed {
        logic                perr;
        logic [BODY_W-1:0]   body;
        logic [ROUTE_W-1:0]  route;
        logic [LABEL_W-1:0]  label;
    } rx_word_t;

    typedef struct packed {
        logic               route_en;
        logic [ROUTE_W-1:0] route_val;
        logic               label_en;
    } filt_cfg_t;

    // Replace the parity bit with an error flag (1 = even ones count)
    function automatic rx_word_t mark_parity(input logic [WORD_W-1:0] raw);
        rx_word_t w;
        w      = rx_word_t'(raw);
        w.perr = ~(^raw);
        return w;
    endfunction

endpackage

// File: rtl/a429f_label_table.sv
module a429f_label_table
    import a429f_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [LABEL_W-1:0] wr_label,
    input  logic [LABEL_W-1:0] probe,
    output logic               hit
);

    logic [LABEL_W-1:0] tab [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
        end else if (wr_en) begin
            tab[wr_idx] <= wr_label;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = (tab[g] == probe);
    end

    assign hit = |match;

    // R5: a write lands in the addressed entry
    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tab[$past(wr_idx)] == $past(wr_label)));

endmodule

// File: rtl/a429f_accept.sv
module a429f_accept
    import a429f_pkg::*;
(
    input  logic              eos,
    input  logic [WORD_W-1:0] raw,
    input  filt_cfg_t         cfg,
    input  logic              label_hit,
    output logic              push,
    output rx_word_t          push_word
);

    rx_word_t w;
    logic     route_ok;
    logic     label_ok;

    always_comb begin
        w         = mark_parity(raw);
        route_ok  = !cfg.route_en || (w.route == cfg.route_val);
        label_ok  = !cfg.label_en || label_hit;
        push      = eos && route_ok && label_ok;
        push_word = w;
    end

endmodule

// File: rtl/a429f_fifo.sv
module a429f_fifo #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 32,
    parameter int HALF_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              rd_strobe,
    input  logic              rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              data_ready,
    output logic              half_full,
    output logic              full,
    output logic              overflow
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  cnt;
    logic              ovf_q;
    logic              do_push, do_pop;
    logic [WORD_W-1:0] head;

    assign do_push = push && (cnt != FULL_CNT);
    assign do_pop  = rd_strobe && rd_sel && (cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (push && (cnt == FULL_CNT)) ovf_q <= 1'b1;
        end
    end

    assign head       = mem[rptr];
    assign rd_data    = rd_sel ? head[WORD_W-1 -: HALF_W] : head[HALF_W-1:0];
    assign data_ready = (cnt != '0);
    assign half_full  = (cnt >= HALF_CNT);
    assign full       = (cnt == FULL_CNT);
    assign overflow   = ovf_q;

    // R9: occupancy never exceeds the depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R10: a word offered at full without a pop leaves the queue full
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (push && full && !(rd_strobe && rd_sel)) |=> (full && $stable(wptr)));

    // R10: overflow is sticky
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8: removing read on empty queue moves nothing
    a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_sel && !data_ready && !push) |=> (!data_ready && $stable(rptr)));

    // R7: strobe on the low half never removes a word
    a_r7_low_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !rd_sel) |=> $stable(rptr));

endmodule

// File: rtl/a429f_word_filter.sv
module a429f_word_filter
    import a429f_pkg::*;
#(
    parameter int FIFO_DEPTH    = 32,
    parameter int LABEL_ENTRIES = 16,
    localparam int IDX_W = (LABEL_ENTRIES > 1) ? $clog2(LABEL_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               eos,
    input  logic               route_en,
    input  logic [ROUTE_W-1:0] route_val,
    input  logic               label_en,
    input  logic               lbl_wr,
    input  logic [IDX_W-1:0]   lbl_idx,
    input  logic [LABEL_W-1:0] lbl_val,
    input  logic               rd_sel,
    input  logic               rd_strobe,
    output logic [HALF_W-1:0]  rd_data,
    output logic               data_ready,
    output logic               half_full,
    output logic               full,
    output logic               overflow
);

    filt_cfg_t cfg;
    logic      label_hit;
    logic      push;
    rx_word_t  push_word;

    assign cfg = '{route_en: route_en, route_val: route_val, label_en: label_en};

    a429f_label_table #(.ENTRIES(LABEL_ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (lbl_wr),
        .wr_idx   (lbl_idx),
        .wr_label (lbl_val),
        .probe    (word_in[LABEL_W-1:0]),
        .hit      (label_hit)
    );

    a429f_accept u_accept (
        .eos       (eos),
        .raw       (word_in),
        .cfg       (cfg),
        .label_hit (label_hit),
        .push      (push),
        .push_word (push_word)
    );

    a429f_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W), .HALF_W(HALF_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_data  (push_word),
        .rd_strobe  (rd_strobe),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .data_ready (data_ready),
        .half_full  (half_full),
        .full       (full),
        .overflow   (overflow)
    );

    // R2: nothing is offered to the queue without the strobe
    a_r2_push_needs_eos: assert property (@(posedge clk) disable iff (rst)
        push |-> eos);

    // R4: label test enabled implies a table hit for every stored word
    a_r4_label_gate: assert property (@(posedge clk) disable iff (rst)
        (push && label_en) |-> label_hit);

    // R3: routing test enabled implies matching bits 9/10
    a_r3_route_gate: assert property (@(posedge clk) disable iff (rst)
        (push && route_en) |-> (word_in[9:8] == route_val));

    // R1: stored top bit is the parity-error flag of the incoming word
    a_r1_flag_bit: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_word[WORD_W-1] == ~(^word_in)));

endmodule

// File: tb/a429f_word_filter_tb_top.sv
module a429f_word_filter_tb_top;

    localparam int CLK_P = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] word_in = '0;
    logic        eos = 1'b0;
    logic        route_en = 1'b0;
    logic [1:0]  route_val = '0;
    logic        label_en = 1'b0;
    logic        lbl_wr = 1'b0;
    logic [3:0]  lbl_idx = '0;
    logic [7:0]  lbl_val = '0;
    logic        rd_sel = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic        data_ready, half_full, full, overflow;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] q[$];
    logic [7:0]  tab [16];
    logic        m_ovf = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    a429f_word_filter dut_i (
        .clk(clk), .rst(rst), .word_in(word_in), .eos(eos),
        .route_en(route_en), .route_val(route_val), .label_en(label_en),
        .lbl_wr(lbl_wr), .lbl_idx(lbl_idx), .lbl_val(lbl_val),
        .rd_sel(rd_sel), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full),
        .overflow(overflow)
    );

    function automatic logic [31:0] exp_store(input logic [31:0] w);
        return {~(^w), w[30:0]};
    endfunction

    function automatic bit exp_accept(input logic [31:0] w);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (tab[i] == w[7:0]) hit = 1;
        if (route_en && (w[9:8] != route_val)) return 0;
        if (label_en && !hit) return 0;
        return 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_status();
        chk("R9 data_ready", {31'd0, data_ready}, {31'd0, q.size() > 0});
        chk("R9 half_full",  {31'd0, half_full},  {31'd0, q.size() >= DEPTH/2});
        chk("R9 full",       {31'd0, full},       {31'd0, q.size() == DEPTH});
        chk("R10 overflow",  {31'd0, overflow},   {31'd0, m_ovf});
    endtask

    task automatic send(input logic [31:0] w);
        word_in = w;
        eos = 1'b1;
        @(posedge clk);
        if (exp_accept(w)) begin
            if (q.size() < DEPTH) q.push_back(exp_store(w));
            else m_ovf = 1'b1;
        end
        @(negedge clk);
        eos = 1'b0;
        word_in = $urandom;
        chk_status();
    endtask

    task automatic write_label(input logic [3:0] idx, input logic [7:0] val);
        lbl_idx = idx;
        lbl_val = val;
        lbl_wr = 1'b1;
        @(posedge clk);
        tab[idx] = val;
        @(negedge clk);
        lbl_wr = 1'b0;
    endtask

    task automatic read_word();
        logic [31:0] e;
        if (q.size() == 0) return;
        e = q[0];
        rd_sel = 1'b0; #1;
        chk("R6 low half", {16'd0, rd_data}, {16'd0, e[15:0]});
        rd_sel = 1'b1; #1;
        chk("R7 high half", {16'd0, rd_data}, {16'd0, e[31:16]});
        rd_strobe = 1'b1;
        @(posedge clk);
        void'(q.pop_front());
        @(negedge clk);
        rd_strobe = 1'b0;
        rd_sel = 1'b0;
        chk_status();
    endtask

    task automatic drain();
        while (q.size() > 0) read_word();
    endtask

    function automatic logic [31:0] mkword(input logic [7:0] lab, input logic [1:0] rt,
                                           input logic [21:0] rest);
        return {rest, rt, lab};
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) tab[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        chk("R11 data_ready", {31'd0, data_ready}, 32'd0);
        chk("R11 half_full",  {31'd0, half_full},  32'd0);
        chk("R11 full",       {31'd0, full},       32'd0);
        chk("R11 overflow",   {31'd0, overflow},   32'd0);

        // R2: word without strobe is not stored
        word_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R2 no eos", {31'd0, data_ready}, 32'd0);

        // R1: odd ones -> flag 0; even ones -> flag 1 and still stored
        send(32'h0000_0001);
        send(32'h8000_0003);
        send(32'hFFFF_FFFF);
        chk("R1 count", q.size(), 3);
        read_word(); read_word(); read_word();

        // R5: cleared table holds label 0 only
        label_en = 1'b1;
        send(mkword(8'h00, 2'b00, 22'h1));
        send(mkword(8'h05, 2'b00, 22'h2));
        chk("R5 cleared table", q.size(), 1);
        drain();

        // R4: programmed labels, no bit reversal
        write_label(4'd3, 8'h01);
        write_label(4'd15, 8'hA7);
        send(mkword(8'h80, 2'b00, 22'h3));
        chk("R4 reversed label rejected", {31'd0, data_ready}, 32'd0);
        send(mkword(8'h01, 2'b00, 22'h4));
        send(mkword(8'hA7, 2'b11, 22'h5));
        send(mkword(8'h5A, 2'b11, 22'h6));
        chk("R4 label hits", q.size(), 2);
        drain();

        // R3: routing bits
        label_en = 1'b0;
        route_en = 1'b1;
        route_val = 2'b10;
        send(mkword(8'h33, 2'b01, 22'h7));
        send(mkword(8'h33, 2'b10, 22'h8));
        chk("R3 route filter", q.size(), 1);
        route_en = 1'b0;
        send(mkword(8'h33, 2'b01, 22'h9));
        chk("R3 route disabled", q.size(), 2);
        drain();

        // R7: low-half strobe does not pop
        send(32'hCAFE_0001);
        rd_sel = 1'b0; rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R7 low strobe keeps", {31'd0, data_ready}, 32'd1);
        drain();

        // R9/R10: fill boundaries, drop at full, sticky overflow
        for (int i = 0; i < 15; i++) send(32'h0100_0000 + i);
        chk("R9 at 15", {31'd0, half_full}, 32'd0);
        send(32'h0100_000F);
        chk("R9 at 16", {31'd0, half_full}, 32'd1);
        for (int i = 16; i < 32; i++) send(32'h0100_0000 + i);
        chk("R9 full", {31'd0, full}, 32'd1);
        send(32'hDEAD_BEEF);
        chk("R10 overflow set", {31'd0, overflow}, 32'd1);
        drain();
        chk("R10 overflow sticky", {31'd0, overflow}, 32'd1);

        // R8: removing read while empty
        rd_sel = 1'b1; rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0; rd_sel = 1'b0;
        chk("R8 empty read", {31'd0, data_ready}, 32'd0);
        send(32'h2468_ACE0);
        read_word();

        // Random phase
        for (int i = 0; i < 16; i++) write_label(4'(i), 8'($urandom));
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom % 10;
            if (op == 0) begin
                route_en = 1'($urandom);
                route_val = 2'($urandom);
                label_en = 1'($urandom);
            end else if (op == 1) begin
                write_label(4'($urandom), 8'($urandom));
            end else if (op < 6) begin
                logic [31:0] w;
                w = $urandom;
                if ($urandom % 2) w[7:0] = tab[$urandom % 16];
                send(w);
            end else begin
                read_word();
            end
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule